// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host byte-wide access into a bank of packet pages. A 16-bit pointer register, loaded one byte at a time, holds a byte offset within a page and two control flags. One flag picks the page source: either the packet-number input or the page at the head of the receive queue. The other flag picks how the offset is formed. In auto-increment mode every data access uses the pointer offset and then advances it. In window mode the pointer stays put and the low two bits of the data-window address are added to the offset.

The page store is a synchronous single-port memory built from four byte-wide lanes. A read strobe returns its data on `reg_rdata_o` one cycle later, and that value is held until the next read. The pointer advances on the same edge that takes the strobe. A host that needs a 16-bit access issues two byte accesses, lower address first. In auto-increment mode this advances the pointer twice.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer is 0x0000 and `reg_rdata_o` is 0x00.
- R2: Writes to register offset 6 load pointer bits [7:0] and writes to offset 7 load bits [15:8]. Reading offset 6 returns bits [7:0]. Reading offset 7 returns bits [15:8] with bit 3 forced to 0, so pointer bit 11 is stored but reads back as 0.
- R3: Register offsets 8 to 11 form the data window. When pointer bit 15 is 1 a data access goes to page `rx_head_i`. When bit 15 is 0 it goes to page `pkt_num_i`.
- R4: When pointer bit 14 is 0, a data access at offset `8+k` uses byte offset `(pointer[10:0] + k) mod 2048`, and the pointer does not change.
- R5: When pointer bit 14 is 1, a data access uses byte offset `pointer[10:0]` whatever `k` is. It then sets `pointer[10:0]` to `(pointer[10:0] + 1) mod 2048` and keeps bits [15:11].
- R6: Read data appears on `reg_rdata_o` in the cycle after the read strobe and holds until the next accepted read.
- R7: If `reg_rd_i` and `reg_wr_i` are both high, only the write is performed. The read is dropped and `reg_rdata_o` holds its value.
- R8: Offsets 0 to 5 and 12 to 15 read as 0x00. Writes to them change neither the pointer nor the memory.
- R9: Back-to-back byte accesses in auto-increment mode each advance the pointer, so two consecutive reads return two consecutive bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register offset of the access |
| reg_wr_i | input | 1 | Write strobe, one cycle per byte |
| reg_rd_i | input | 1 | Read strobe, one cycle per byte |
| reg_wdata_i | input | 8 | Write data byte |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| pkt_num_i | input | PAGE_W | Page used when pointer bit 15 is 0 |
| rx_head_i | input | PAGE_W | Page used when pointer bit 15 is 1 |

## Verification
A single data-window strobe does two things on the same edge: it addresses the memory and it advances the pointer. The access must see the offset from before the increment. The bench exercises this with runs of back-to-back auto-increment reads and writes, with an access at offset 0x7FF that wraps to zero, and with a pointer readback placed right after an access. A cycle-level reference model predicts the data byte and the pointer readback for every cycle, and the bench compares them with `reg_rdata_o`. The case where a read and a write strobe fall in the same cycle is also driven, and it is judged by checking that the output is held and the write lands.

// File: rtl/pkt_data_port_pkg.sv
package pkt_data_port_pkg;
  localparam int PTR_W     = 16;
  localparam int BIT_RXSEL = 15;
  localparam int BIT_AUTO  = 14;
  localparam int LANES     = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PTR_LO,
    SEL_PTR_HI,
    SEL_DATA
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [3:0] a);
    case (a)
      4'd6:                      decode = SEL_PTR_LO;
      4'd7:                      decode = SEL_PTR_HI;
      4'd8, 4'd9, 4'd10, 4'd11:  decode = SEL_DATA;
      default:                   decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pdp_ptr_ctrl.sv
module pdp_ptr_ctrl
  import pkt_data_port_pkg::*;
#(
  parameter int OFF_W  = 11,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        wdata_i,
  input  logic              acc_i,
  input  logic [1:0]        lane_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  input  logic [PAGE_W-1:0] rx_head_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             auto_inc;

  assign auto_inc = ptr_q[BIT_AUTO];
  assign page_o   = ptr_q[BIT_RXSEL] ? rx_head_i : pkt_num_i;
  assign off_o    = auto_inc ? ptr_q[OFF_W-1:0]
                             : ptr_q[OFF_W-1:0] + OFF_W'(lane_i);
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i) begin
      ptr_q[7:0] <= wdata_i;
    end else if (wr_hi_i) begin
      ptr_q[15:8] <= wdata_i;
    end else if (acc_i && auto_inc) begin
      // offset field wraps; flags and upper bits kept
      ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + 1'b1;
    end
  end
endmodule

// File: rtl/pdp_lane_ram.sv
module pdp_lane_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pkt_data_port_pkg::*;
#(
  parameter int PAGES  = 4,
  parameter int OFF_W  = 11,
  parameter int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [PAGE_W-1:0] pkt_num_i,
  input  logic [PAGE_W-1:0] rx_head_i
);
  localparam int LANE_AW    = PAGE_W + OFF_W - 2;
  localparam int LANE_DEPTH = PAGES * (2 ** (OFF_W - 2));

  reg_sel_e           sel;
  logic               rd_eff;
  logic               acc;
  logic [PTR_W-1:0]   ptr_w;
  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   off;
  logic [LANE_AW-1:0] lane_addr;
  logic [7:0]         lane_rd [LANES];
  logic [7:0]         regval_d, regval_q;
  logic               from_ram_q;
  logic [1:0]         lane_q;

  assign sel       = decode(reg_addr_i);
  assign rd_eff    = reg_rd_i && !reg_wr_i;
  assign acc       = (sel == SEL_DATA) && (reg_wr_i || rd_eff);
  assign lane_addr = {page, off[OFF_W-1:2]};

  pdp_ptr_ctrl #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (reg_wr_i && sel == SEL_PTR_LO),
    .wr_hi_i   (reg_wr_i && sel == SEL_PTR_HI),
    .wdata_i   (reg_wdata_i),
    .acc_i     (acc),
    .lane_i    (reg_addr_i[1:0]),
    .pkt_num_i (pkt_num_i),
    .rx_head_i (rx_head_i),
    .ptr_o     (ptr_w),
    .page_o    (page),
    .off_o     (off)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pdp_lane_ram #(.DEPTH(LANE_DEPTH), .AW(LANE_AW)) u_ram (
      .clk_i   (clk_i),
      .we_i    (reg_wr_i && sel == SEL_DATA && off[1:0] == 2'(g)),
      .re_i    (rd_eff && sel == SEL_DATA),
      .addr_i  (lane_addr),
      .wdata_i (reg_wdata_i),
      .rdata_o (lane_rd[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_PTR_LO: regval_d = ptr_w[7:0];
      SEL_PTR_HI: regval_d = ptr_w[15:8] & 8'hF7;
      default:    regval_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regval_q   <= '0;
      from_ram_q <= 1'b0;
      lane_q     <= '0;
    end else if (rd_eff) begin
      regval_q   <= regval_d;
      from_ram_q <= (sel == SEL_DATA);
      lane_q     <= off[1:0];
    end
  end

  assign reg_rdata_o = from_ram_q ? lane_rd[lane_q] : regval_q;
endmodule

// File: rtl/pdp_port_chk.sv
module pdp_port_chk #(
  parameter int OFF_W = 11
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  reg_addr_i,
  input logic        reg_wr_i,
  input logic        reg_rd_i,
  input logic [7:0]  reg_rdata_o,
  input logic [15:0] ptr_i
);
  logic win, rd_ok, unmapped;
  assign win      = reg_addr_i >= 4'd8 && reg_addr_i <= 4'd11;
  assign rd_ok    = reg_rd_i && !reg_wr_i;
  assign unmapped = reg_addr_i < 4'd6 || reg_addr_i > 4'd11;

  assert_auto_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && (reg_wr_i || reg_rd_i) && ptr_i[14]) |=>
      (ptr_i[OFF_W-1:0] == OFF_W'($past(ptr_i[OFF_W-1:0]) + 1'b1)) &&
      (ptr_i[15:OFF_W] == $past(ptr_i[15:OFF_W])));

  assert_window_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && (reg_wr_i || reg_rd_i) && !ptr_i[14]) |=> $stable(ptr_i));

  assert_hi_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && reg_addr_i == 4'd7) |=> !reg_rdata_o[3]);

  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && unmapped) |=> reg_rdata_o == 8'h00);

  assert_unmapped_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && unmapped) |=> $stable(ptr_i));

  assert_rdata_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok |=> $stable(reg_rdata_o));
endmodule

bind pkt_data_port pdp_port_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .ptr_i       (ptr_w)
);

// File: tb/pkt_data_port_tb.sv
module pkt_data_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [1:0] pkt_num_i = '0, rx_head_i = '0;

  int n_vec = 0, n_bad = 0;
  int ptr_m = 0;
  logic [7:0] exp_m = 8'h00;
  logic [7:0] mem_m [int];
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pkt_data_port u_dut (.*);

  function automatic void model_edge(bit rd, bit wr, int a, int wd);
    bit re = rd && !wr;
    int pg, off, k;
    if (re) begin
      if (a == 6) exp_m = 8'(ptr_m & 'hFF);
      else if (a == 7) exp_m = 8'((ptr_m >> 8) & 'hF7);
      else if (a < 8 || a > 11) exp_m = 8'h00;
    end
    if (wr && a == 6) begin ptr_m = (ptr_m & 'hFF00) | wd; return; end
    if (wr && a == 7) begin ptr_m = (ptr_m & 'h00FF) | (wd << 8); return; end
    if (a >= 8 && a <= 11 && (rd || wr)) begin
      k   = a - 8;
      pg  = ptr_m[15] ? int'(rx_head_i) : int'(pkt_num_i);
      off = ptr_m[14] ? (ptr_m & 'h7FF) : ((ptr_m + k) & 'h7FF);
      if (wr) mem_m[pg * 2048 + off] = 8'(wd);
      else exp_m = mem_m.exists(pg * 2048 + off) ? mem_m[pg * 2048 + off] : 8'hxx;
      if (ptr_m[14]) ptr_m = (ptr_m & 'hF800) | ((ptr_m + 1) & 'h7FF);
    end
  endfunction

  task automatic step(bit rd, bit wr, int a, int wd, string tag);
    reg_rd_i = rd; reg_wr_i = wr; reg_addr_i = 4'(a); reg_wdata_i = 8'(wd);
    @(posedge clk_i);
    model_edge(rd, wr, a, wd);
    @(negedge clk_i);
    if (!$isunknown(exp_m)) begin
      n_vec++;
      if (reg_rdata_o !== exp_m) begin
        n_bad++;
        $display("FAIL %s: rdata=%02h expected=%02h", tag, reg_rdata_o, exp_m);
      end
    end
    reg_rd_i = 0; reg_wr_i = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    n_vec++;
    if (reg_rdata_o !== 8'h00) begin
      n_bad++; $display("FAIL R1: rdata=%02h expected=00", reg_rdata_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1, 0, 6, 0, "R1"); step(1, 0, 7, 0, "R1");
    // R2: pointer bytes, bit 11 masked on readback
    step(0, 1, 6, 'h5A, "R2"); step(0, 1, 7, 'h0F, "R2");
    step(1, 0, 6, 0, "R2"); step(1, 0, 7, 0, "R2");
    // R5/R9: auto-increment fill of page 2, back-to-back
    pkt_num_i = 2;
    step(0, 1, 6, 'h10, "R5"); step(0, 1, 7, 'h40, "R5");
    for (int i = 0; i < 8; i++) step(0, 1, 8 + (i % 4), 'hA0 + i, "R9");
    step(1, 0, 6, 0, "R5");
    step(0, 1, 6, 'h10, "R5");
    for (int i = 0; i < 8; i++) step(1, 0, 11 - (i % 4), 0, "R9");
    step(1, 0, 6, 0, "R9");
    // R4: window mode, lane added, pointer frozen
    step(0, 1, 7, 'h00, "R4"); step(0, 1, 6, 'h12, "R4");
    for (int k = 0; k < 4; k++) step(1, 0, 8 + k, 0, "R4");
    step(0, 1, 10, 'h77, "R4"); step(1, 0, 8, 0, "R4"); step(1, 0, 6, 0, "R4");
    // R4: window offset wraps past 0x7FF
    step(0, 1, 7, 'h07, "R4"); step(0, 1, 6, 'hFE, "R4");
    for (int k = 0; k < 4; k++) step(0, 1, 8 + k, 'h30 + k, "R4");
    step(0, 1, 7, 'h00, "R4"); step(0, 1, 6, 'h00, "R4");
    step(1, 0, 8, 0, "R4"); step(1, 0, 9, 0, "R4");
    // R5: auto-increment wraps at 0x7FF, upper bits kept
    step(0, 1, 7, 'h4F, "R5"); step(0, 1, 6, 'hFF, "R5");
    step(0, 1, 8, 'hE1, "R5"); step(1, 0, 6, 0, "R5"); step(1, 0, 7, 0, "R5");
    // R3: rx-head page select
    rx_head_i = 1; pkt_num_i = 3;
    step(0, 1, 7, 'hC0, "R3"); step(0, 1, 6, 'h20, "R3");
    step(0, 1, 8, 'h3C, "R3"); step(0, 1, 6, 'h20, "R3");
    rx_head_i = 3; pkt_num_i = 1;
    step(0, 1, 8, 'hC3, "R3");
    step(0, 1, 7, 'h40, "R3"); step(0, 1, 6, 'h20, "R3");
    step(1, 0, 8, 0, "R3");
    rx_head_i = 1; step(0, 1, 7, 'hC0, "R3"); step(0, 1, 6, 'h20, "R3");
    step(1, 0, 8, 0, "R3");
    // R7: simultaneous strobes, write wins
    step(1, 0, 7, 0, "R7");
    step(1, 1, 6, 'h33, "R7"); step(0, 0, 0, 0, "R7");
    step(1, 0, 6, 0, "R7");
    // R6: hold across idle cycles
    for (int i = 0; i < 3; i++) step(0, 0, 6, 0, "R6");
    // R8: unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a < 6 || a > 11) begin
        step(0, 1, a, 'hFF, "R8"); step(1, 0, a, 0, "R8");
      end
    end
    step(1, 0, 6, 0, "R8"); step(1, 0, 7, 0, "R8");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: rdata=%02h expected=completion", reg_rdata_o);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule